// File: doc/BRIEF.md
# Timer Output Compare Unit with Event Trigger

The block watches one of two free-running 16-bit timers and compares the selected count with a programmable 16-bit compare value on every clock. When the two become equal, the block applies the action chosen by a 4-bit mode code to a dedicated compare output latch. The action is drive high, drive low, toggle, or leave alone. The same match raises a one-cycle interrupt flag.

In event-trigger mode the match also emits a one-cycle pulse that clears the first timer, so the compare value acts as that timer's period. The same pulse asks the converter to start a conversion when the converter is enabled.

Writing the mode code to zero turns the unit off and returns the output latch to low. The timers and the converter sit outside the block; it only consumes their counts and produces the clear and start pulses.

Top module: `oc_compare_unit`

## Requirements
- R1: After reset, cmp_out, match_flag, tmr_clear and adc_go are all 0.
- R2: tmr_sel=0 compares cmp_val with tmr_a and tmr_sel=1 compares it with tmr_b; the unselected timer has no effect.
- R3: With mode 4'b1000 a match drives cmp_out to 1 on the clock edge where the equality is first seen; match_flag is 1 for the cycle after that edge.
- R4: With mode 4'b1001 a match drives cmp_out to 0, and match_flag pulses.
- R5: With mode 4'b0010 each match inverts cmp_out, and match_flag pulses.
- R6: With mode 4'b1010 a match pulses match_flag and leaves cmp_out unchanged.
- R7: A match produces exactly one single-cycle pulse per equality event; while the selected timer stays equal to cmp_val no further pulse occurs.
- R8: With mode 4'b0000 cmp_out is forced to 0 at the next clock edge, and no pulse is produced.
- R9: With mode 4'b1011 a match pulses match_flag and tmr_clear together and leaves cmp_out unchanged. When adc_en=1, adc_go pulses in the same cycle.
- R10: In mode 4'b1011 with adc_en=0 a match leaves adc_go at 0, while match_flag and tmr_clear still pulse.
- R11: Any other mode code produces no pulse and leaves cmp_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Compare mode code |
| tmr_sel | input | 1 | Timer select: 0 = tmr_a, 1 = tmr_b |
| tmr_a | input | 16 | First timer count |
| tmr_b | input | 16 | Second timer count |
| cmp_val | input | 16 | Compare value |
| adc_en | input | 1 | Converter enabled |
| cmp_out | output | 1 | Compare output latch |
| match_flag | output | 1 | One-cycle interrupt flag pulse |
| tmr_clear | output | 1 | One-cycle clear pulse for the first timer |
| adc_go | output | 1 | One-cycle conversion start request |

## Verification
The hardest case is a second match while the timer still holds the compare value, because a level-sensitive design would pulse again. The stimulus holds the timer equal to the compare value for an extra cycle and expects silence. It then steps the timer off the value and back onto it, which must give a fresh pulse. Each mode scenario begins with a non-matching count, so the equality history is cleared before the match under test.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;

    localparam int OC_TW     = 16;
    localparam int OC_MODE_W = 4;

    typedef enum logic [OC_MODE_W-1:0] {
        OC_OFF    = 4'b0000,
        OC_TOGGLE = 4'b0010,
        OC_SET    = 4'b1000,
        OC_CLR    = 4'b1001,
        OC_SOFT   = 4'b1010,
        OC_EVENT  = 4'b1011
    } oc_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_HIGH,
        ACT_LOW,
        ACT_FLIP
    } pin_act_e;

    typedef struct packed {
        logic     active;
        pin_act_e act;
        logic     event_trig;
        logic     force_low;
    } oc_ctrl_t;

    typedef struct packed {
        logic irq;
        logic tclr;
        logic adc;
    } oc_pulse_t;

    function automatic oc_ctrl_t oc_decode(input logic [OC_MODE_W-1:0] m);
        oc_ctrl_t c;
        c = '{active: 1'b0, act: ACT_HOLD, event_trig: 1'b0, force_low: 1'b0};
        case (m)
            OC_OFF:    c.force_low = 1'b1;
            OC_TOGGLE: begin c.active = 1'b1; c.act = ACT_FLIP; end
            OC_SET:    begin c.active = 1'b1; c.act = ACT_HIGH; end
            OC_CLR:    begin c.active = 1'b1; c.act = ACT_LOW;  end
            OC_SOFT:   c.active = 1'b1;
            OC_EVENT:  begin c.active = 1'b1; c.event_trig = 1'b1; end
            default:   ;
        endcase
        return c;
    endfunction

    function automatic logic oc_apply(input pin_act_e a, input logic cur);
        case (a)
            ACT_HIGH: return 1'b1;
            ACT_LOW:  return 1'b0;
            ACT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/oc_mode_decode.sv
`timescale 1ns/1ps
module oc_mode_decode
    import oc_pkg::*;
(
    input  logic [OC_MODE_W-1:0] mode,
    output oc_ctrl_t             ctrl
);
    always_comb ctrl = oc_decode(mode);
endmodule

// File: rtl/oc_match_detect.sv
`timescale 1ns/1ps
module oc_match_detect #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic [TW-1:0] cmp,
    output logic          hit
);
    logic [TW-1:0] tmr_cur;
    logic          eq;
    logic          eq_q;

    always_comb begin
        tmr_cur = sel ? tmr_b : tmr_a;
        eq      = (tmr_cur == cmp);
        hit     = eq & ~eq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end
endmodule

// File: rtl/oc_pin_latch.sv
`timescale 1ns/1ps
module oc_pin_latch
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     force_low,
    input  logic     fire,
    input  pin_act_e act,
    output logic     pin
);
    always_ff @(posedge clk) begin
        if (rst || force_low) pin <= 1'b0;
        else if (fire)        pin <= oc_apply(act, pin);
    end
endmodule

// File: rtl/oc_compare_unit.sv
`timescale 1ns/1ps
module oc_compare_unit
    import oc_pkg::*;
#(
    parameter int TW = OC_TW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OC_MODE_W-1:0] mode,
    input  logic                 tmr_sel,
    input  logic [TW-1:0]        tmr_a,
    input  logic [TW-1:0]        tmr_b,
    input  logic [TW-1:0]        cmp_val,
    input  logic                 adc_en,
    output logic                 cmp_out,
    output logic                 match_flag,
    output logic                 tmr_clear,
    output logic                 adc_go
);
    oc_ctrl_t  ctrl;
    logic      hit;
    logic      fire;
    oc_pulse_t pulse_d, pulse_q;

    oc_mode_decode u_dec (.mode(mode), .ctrl(ctrl));

    oc_match_detect #(.TW(TW)) u_match (
        .clk(clk), .rst(rst), .sel(tmr_sel),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .cmp(cmp_val), .hit(hit)
    );

    assign fire = hit & ctrl.active;

    oc_pin_latch u_pin (
        .clk(clk), .rst(rst), .force_low(ctrl.force_low),
        .fire(fire), .act(ctrl.act), .pin(cmp_out)
    );

    always_comb begin
        pulse_d.irq  = fire;
        pulse_d.tclr = fire & ctrl.event_trig;
        pulse_d.adc  = fire & ctrl.event_trig & adc_en;
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= pulse_d;
    end

    assign match_flag = pulse_q.irq;
    assign tmr_clear  = pulse_q.tclr;
    assign adc_go     = pulse_q.adc;
endmodule

// File: rtl/oc_compare_unit_chk.sv
`timescale 1ns/1ps
module oc_compare_unit_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    mode,
    input logic          tmr_sel,
    input logic [TW-1:0] tmr_a,
    input logic [TW-1:0] tmr_b,
    input logic [TW-1:0] cmp_val,
    input logic          cmp_out,
    input logic          match_flag,
    input logic          tmr_clear,
    input logic          adc_go
);
    logic [TW-1:0] sel_t;
    assign sel_t = tmr_sel ? tmr_b : tmr_a;

    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        match_flag |=> !match_flag); // R7
    AST_CLEAR_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        tmr_clear |-> match_flag); // R9
    AST_ADC_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        adc_go |-> tmr_clear); // R10
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b0000) |=> !cmp_out); // R8
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1010) |=> $stable(cmp_out)); // R6
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1000 && sel_t == cmp_val) |=> cmp_out); // R3
endmodule

bind oc_compare_unit oc_compare_unit_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .tmr_sel(tmr_sel),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .cmp_val(cmp_val),
    .cmp_out(cmp_out), .match_flag(match_flag),
    .tmr_clear(tmr_clear), .adc_go(adc_go)
);

// File: tb/oc_compare_unit_test.sv
`timescale 1ns/1ps
module oc_compare_unit_test;

    typedef struct {
        logic  pin;
        logic  flag;
        logic  tclr;
        logic  adc;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'b0000;
    logic        tmr_sel = 1'b0;
    logic [15:0] tmr_a = 16'd0, tmr_b = 16'd0, cmp_val = 16'd100;
    logic        adc_en = 1'b0;
    logic        cmp_out, match_flag, tmr_clear, adc_go;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    oc_compare_unit uut (
        .clk(clk), .rst(rst), .mode(mode), .tmr_sel(tmr_sel),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .cmp_val(cmp_val), .adc_en(adc_en),
        .cmp_out(cmp_out), .match_flag(match_flag),
        .tmr_clear(tmr_clear), .adc_go(adc_go)
    );

    task automatic cmp4(input logic p, f, t, a, input string req);
        checks++;
        if ({cmp_out, match_flag, tmr_clear, adc_go} !== {p, f, t, a}) begin
            errors++;
            $display("FAIL %s: got pin/flag/clr/adc=%b%b%b%b expected %b%b%b%b",
                     req, cmp_out, match_flag, tmr_clear, adc_go, p, f, t, a);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outputs after the next edge
    task automatic step(input logic [3:0] m, input logic s, input logic [15:0] a,
                        input logic [15:0] b, input logic ae,
                        input logic ep, ef, et, ea, input string req);
        exp_t e;
        @(negedge clk);
        mode = m; tmr_sel = s; tmr_a = a; tmr_b = b; adc_en = ae;
        e.pin = ep; e.flag = ef; e.tclr = et; e.adc = ea; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp4(e.pin, e.flag, e.tclr, e.adc, e.req);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp4(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
        // R3 set high
        step(4'b1000, 0, 16'd50,  16'd0, 0, 0, 0, 0, 0, "R3 no match");
        step(4'b1000, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R3 set high");
        // R7 held equality gives no second pulse
        step(4'b1000, 0, 16'd100, 16'd0, 0, 1, 0, 0, 0, "R7 held equal");
        step(4'b1000, 0, 16'd101, 16'd0, 0, 1, 0, 0, 0, "R7 leave");
        // R4 set low
        step(4'b1001, 0, 16'd100, 16'd0, 0, 0, 1, 0, 0, "R4 set low");
        // R5 toggle
        step(4'b0010, 0, 16'd101, 16'd0, 0, 0, 0, 0, 0, "R5 idle");
        step(4'b0010, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R5 toggle up");
        step(4'b0010, 0, 16'd99,  16'd0, 0, 1, 0, 0, 0, "R5 idle");
        step(4'b0010, 0, 16'd100, 16'd0, 0, 0, 1, 0, 0, "R5 toggle down");
        // R8 off forces low
        step(4'b1000, 0, 16'd99,  16'd0, 0, 0, 0, 0, 0, "R8 prep");
        step(4'b1000, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R8 prep high");
        step(4'b0000, 0, 16'd5,   16'd0, 0, 0, 0, 0, 0, "R8 forced low");
        step(4'b0000, 0, 16'd100, 16'd0, 0, 0, 0, 0, 0, "R8 off no pulse");
        // R6 interrupt only
        step(4'b1010, 0, 16'd5,   16'd0, 0, 0, 0, 0, 0, "R6 idle");
        step(4'b1010, 0, 16'd100, 16'd0, 0, 0, 1, 0, 0, "R6 flag pin low");
        step(4'b1000, 0, 16'd1,   16'd0, 0, 0, 0, 0, 0, "R6 prep");
        step(4'b1000, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R6 prep high");
        step(4'b1010, 0, 16'd1,   16'd0, 0, 1, 0, 0, 0, "R6 idle");
        step(4'b1010, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R6 flag pin high");
        // R2 timer select
        step(4'b1001, 1, 16'd100, 16'd7,   0, 1, 0, 0, 0, "R2 tmr_a ignored");
        step(4'b1001, 1, 16'd100, 16'd100, 0, 0, 1, 0, 0, "R2 tmr_b match");
        // R9 event trigger with converter on
        step(4'b1011, 0, 16'd3,   16'd0, 1, 0, 0, 0, 0, "R9 idle");
        step(4'b1011, 0, 16'd100, 16'd0, 1, 0, 1, 1, 1, "R9 event");
        step(4'b1011, 0, 16'd100, 16'd0, 1, 0, 0, 0, 0, "R9 single pulse");
        // R10 converter off
        step(4'b1011, 0, 16'd3,   16'd0, 0, 0, 0, 0, 0, "R10 idle");
        step(4'b1011, 0, 16'd100, 16'd0, 0, 0, 1, 1, 0, "R10 no adc");
        // R9 pin unchanged when high
        step(4'b1000, 0, 16'd3,   16'd0, 0, 0, 0, 0, 0, "R9 prep");
        step(4'b1000, 0, 16'd100, 16'd0, 0, 1, 1, 0, 0, "R9 prep high");
        step(4'b1011, 0, 16'd3,   16'd0, 1, 1, 0, 0, 0, "R9 idle");
        step(4'b1011, 0, 16'd100, 16'd0, 1, 1, 1, 1, 1, "R9 pin kept high");
        // R11 unassigned mode
        step(4'b0100, 0, 16'd3,   16'd0, 1, 1, 0, 0, 0, "R11 idle");
        step(4'b0100, 0, 16'd100, 16'd0, 1, 1, 0, 0, 0, "R11 no action");
        step(4'b1111, 0, 16'd3,   16'd0, 1, 1, 0, 0, 0, "R11 idle");
        step(4'b1111, 0, 16'd100, 16'd0, 1, 1, 0, 0, 0, "R11 no action");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule